// File: doc/BRIEF.md
# Sequential Sum, Divide-by-Eight and Round Unit

The unit adds four unsigned 8-bit operands, presented one at a time, into a single accumulator. It then divides the total by eight and rounds the quotient half-up to the nearest integer. The datapath has one accumulator, one operand counter and a shift-and-round stage. A small controller orders the work: on an accepted start it clears the accumulator, adds one operand per accepted strobe, then latches the rounded quotient into the result register.

A host waits for `ready_o` and pulses `start_i`. It then presents operands on `opnd_i` with `opnd_valid_i` high, one per cycle, and may stall freely by holding the strobe low. When `ready_o` rises again, `result_o` holds the answer. The answer stays there until the next job completes.

Top module: `sum_round_unit`

## Requirements
- R1: After reset `ready_o` is 1 and `result_o` is 0.
- R2: `ready_o` is 1 only while the unit is idle. A start sampled at a clock edge while `ready_o` is 1 drives `ready_o` low from that edge on.
- R3: An accepted start clears the accumulator, so a result depends only on the four operands of its own job.
- R4: Exactly four operands are accepted per job. The edge after the edge that accepts the fourth operand latches the result, and `ready_o` is 1 from that edge on.
- R5: An operand is accepted only on an edge where `opnd_valid_i` is 1 during accumulation. While the strobe is 0, the running sum and the operand count hold.
- R6: With sum S of the four operands, the result is S shifted right by 3, plus 1 when S modulo 8 (the low three bits) is greater than 3.
- R7: The result is 8 bits wide and never exceeds 128, the value for four operands of 255.
- R8: A `start_i` pulse while `ready_o` is 0 is ignored: the job in progress and its result are unchanged.
- R9: While idle, `result_o` holds its value, and `opnd_i` and `opnd_valid_i` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a job; honoured only while ready_o is 1 |
| ready_o | output | 1 | Unit idle and able to accept a start |
| opnd_i | input | 8 | Unsigned operand |
| opnd_valid_i | input | 1 | Operand strobe during accumulation |
| result_o | output | 8 | Rounded quotient of the last completed job |

## Verification
The hardest cases to reach from the ports are a start pulse that lands in the middle of a stalled accumulation, and stray operands driven while the unit is idle. The stimulus inserts random stall cycles between operands. During those stalls it sometimes raises `start_i` and drives junk on `opnd_i`, and between jobs it drives strobed junk while idle. The rounding boundary is reached directly with sums whose low three bits are 3 and 4, and with the all-ones job.

// File: rtl/sru_pkg.sv
`timescale 1ns/1ps
package sru_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_RND  = 2'd2
  } sru_state_e;
endpackage

// File: rtl/sru_ctrl.sv
`timescale 1ns/1ps
module sru_ctrl
  import sru_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       opnd_valid_i,
  input  logic       last_i,
  output sru_state_e state_o,
  output logic       clear_o,
  output logic       add_o,
  output logic       latch_o,
  output logic       ready_o
);
  sru_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ACC;
      ST_ACC:  if (opnd_valid_i && last_i) state_d = ST_RND;
      ST_RND:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o = (state_q == ST_IDLE);
  assign clear_o = ready_o && start_i;
  assign add_o   = (state_q == ST_ACC) && opnd_valid_i;
  assign latch_o = (state_q == ST_RND);
  assign state_o = state_q;
endmodule

// File: rtl/sru_accum.sv
`timescale 1ns/1ps
module sru_accum #(
  parameter int OPND_W   = 8,
  parameter int NUM_OPND = 4,
  parameter int ACC_W    = OPND_W + $clog2(NUM_OPND),
  parameter int CNT_W    = $clog2(NUM_OPND)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [OPND_W-1:0] opnd_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              last_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_OPND - 1);

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (add_i) begin
      acc_q <= acc_q + {{(ACC_W-OPND_W){1'b0}}, opnd_i};
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign acc_o  = acc_q;
  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST_IDX);
endmodule

// File: rtl/sru_round.sv
`timescale 1ns/1ps
module sru_round #(
  parameter int ACC_W = 10,
  parameter int SHIFT = 3,
  parameter int RES_W = ACC_W - SHIFT + 1
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [RES_W-1:0] res_o
);
  generate
    if (SHIFT == 0) begin : g_pass
      assign res_o = RES_W'(acc_i);
    end else begin : g_shift
      localparam logic [SHIFT-1:0] RND_LIM = SHIFT'((1 << (SHIFT - 1)) - 1);
      logic [ACC_W-SHIFT-1:0] quo;
      logic [SHIFT-1:0]       rem;
      logic                   inc;
      assign quo   = acc_i[ACC_W-1:SHIFT];
      assign rem   = acc_i[SHIFT-1:0];
      assign inc   = (rem > RND_LIM);  // half-up
      assign res_o = RES_W'(quo) + RES_W'(inc);
    end
  endgenerate
endmodule

// File: rtl/sum_round_unit.sv
`timescale 1ns/1ps
module sum_round_unit
  import sru_pkg::*;
#(
  parameter int OPND_W   = 8,
  parameter int NUM_OPND = 4,
  parameter int SHIFT    = 3,
  localparam int ACC_W   = OPND_W + $clog2(NUM_OPND),
  localparam int CNT_W   = $clog2(NUM_OPND),
  localparam int RES_W   = ACC_W - SHIFT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              ready_o,
  input  logic [OPND_W-1:0] opnd_i,
  input  logic              opnd_valid_i,
  output logic [RES_W-1:0]  result_o
);
  sru_state_e       state_q;
  logic             clear, add, latch, last;
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] rnd, res_q;

  sru_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .opnd_valid_i(opnd_valid_i), .last_i(last), .state_o(state_q),
    .clear_o(clear), .add_o(add), .latch_o(latch), .ready_o(ready_o)
  );

  sru_accum #(.OPND_W(OPND_W), .NUM_OPND(NUM_OPND), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .add_i(add),
    .opnd_i(opnd_i), .acc_o(acc_q), .cnt_o(cnt_q), .last_o(last)
  );

  sru_round #(.ACC_W(ACC_W), .SHIFT(SHIFT), .RES_W(RES_W)) u_round (
    .acc_i(acc_q), .res_o(rnd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_q <= '0;
    else if (latch) res_q <= rnd;
  end

  assign result_o = res_q;
endmodule

// File: rtl/sum_round_unit_chk.sv
`timescale 1ns/1ps
module sum_round_unit_chk
  import sru_pkg::*;
#(
  parameter int OPND_W   = 8,
  parameter int NUM_OPND = 4,
  parameter int SHIFT    = 3,
  parameter int ACC_W    = 10,
  parameter int CNT_W    = 2,
  parameter int RES_W    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             opnd_valid_i,
  input logic             ready_o,
  input logic [RES_W-1:0] result_o,
  input sru_state_e       state_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [ACC_W-1:0] acc_q
);
  localparam int MAX_SUM = NUM_OPND * ((1 << OPND_W) - 1);
  localparam logic [RES_W-1:0] MAX_RES =
    RES_W'((MAX_SUM + ((SHIFT > 0) ? (1 << (SHIFT - 1)) : 0)) >> SHIFT);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_OPND - 1);

  AST_START_LEAVES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && start_i |=> !ready_o);  // R2
  AST_CLEAR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && start_i |=> acc_q == '0 && cnt_q == '0);  // R3
  AST_FOURTH_ENDS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ACC && opnd_valid_i && cnt_q == LAST_IDX |=> state_q == ST_RND);  // R4
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ACC && !opnd_valid_i |=> $stable(cnt_q) && $stable(acc_q));  // R5
  AST_RESULT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o <= MAX_RES);  // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ACC && start_i && !opnd_valid_i |=> state_q == ST_ACC);  // R8
  AST_IDLE_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !start_i |=> $stable(result_o));  // R9
endmodule

bind sum_round_unit sum_round_unit_chk #(
  .OPND_W(OPND_W), .NUM_OPND(NUM_OPND), .SHIFT(SHIFT),
  .ACC_W(ACC_W), .CNT_W(CNT_W), .RES_W(RES_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .opnd_valid_i(opnd_valid_i),
  .ready_o(ready_o), .result_o(result_o), .state_q(state_q), .cnt_q(cnt_q), .acc_q(acc_q)
);

// File: tb/sum_round_unit_tb_top.sv
`timescale 1ns/1ps
module sum_round_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       opnd_valid_i = 1'b0;
  logic [7:0] opnd_i = '0;
  logic       ready_o;
  logic [7:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  sum_round_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_o(ready_o),
    .opnd_i(opnd_i), .opnd_valid_i(opnd_valid_i), .result_o(result_o)
  );

  function automatic int exp_res(int s);
    return (s >> 3) + (((s & 7) > 3) ? 1 : 0);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run_job(int o0, int o1, int o2, int o3, int stall_pct, bit poke, string tag);
    int ops[4];
    int sum;
    ops = '{o0, o1, o2, o3};
    sum = o0 + o1 + o2 + o3;
    check({"R2 ready before start ", tag}, int'(ready_o), 1);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check({"R2 ready low after start ", tag}, int'(ready_o), 0);
    for (int i = 0; i < 4; i++) begin
      while (($urandom % 100) < stall_pct) begin
        opnd_valid_i = 1'b0;
        opnd_i = 8'($urandom);
        start_i = poke && ($urandom % 2 == 0);  // R8 busy start
        @(negedge clk_i);
        start_i = 1'b0;
        check({"R5 ready low while stalled ", tag}, int'(ready_o), 0);
      end
      opnd_valid_i = 1'b1;
      opnd_i = 8'(ops[i]);
      @(negedge clk_i);
    end
    opnd_valid_i = 1'b0;
    opnd_i = 8'($urandom);
    check({"R4 ready low in round cycle ", tag}, int'(ready_o), 0);
    @(negedge clk_i);
    check({"R4 ready back after four ", tag}, int'(ready_o), 1);
    check({"R6 R3 R8 result ", tag}, int'(result_o), exp_res(sum));
  endtask

  task automatic idle_junk(int n);
    int held;
    held = int'(result_o);
    for (int i = 0; i < n; i++) begin
      opnd_valid_i = 1'b1;
      opnd_i = 8'($urandom);
      @(negedge clk_i);
    end
    opnd_valid_i = 1'b0;
    check("R9 result held in idle", int'(result_o), held);
    check("R9 ready stays high in idle", int'(ready_o), 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    check("R1 ready after reset", int'(ready_o), 1);
    check("R1 result after reset", int'(result_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_job(0, 0, 0, 0, 0, 0, "zero");
    run_job(255, 255, 255, 255, 0, 0, "max R7");
    run_job(1, 2, 3, 5, 0, 0, "rem3 R3");       // 11 -> 1
    run_job(1, 2, 4, 5, 0, 0, "rem4");          // 12 -> 2
    run_job(7, 0, 0, 0, 30, 1, "7");            // 7 -> 1
    run_job(0, 0, 0, 3, 0, 0, "3");             // 3 -> 0
    run_job(255, 255, 255, 250, 50, 1, "1015"); // 1015 -> 127
    idle_junk(4);
    for (int j = 0; j < 40; j++) begin
      run_job(int'($urandom % 256), int'($urandom % 256), int'($urandom % 256),
              int'($urandom % 256), 40, 1, "random");
      idle_junk(1 + int'($urandom % 3));
    end
    done = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end
endmodule